// File: doc/BRIEF.md
# Ethernet Buffer Command and Status Register

This block is the 8-bit register through which a processor drives an Ethernet packet buffer controller. The low nibble is a command field: writing a recognised code makes the block issue one single-cycle strobe to the buffer logic, and then the field clears itself. The three bits above it are interrupt flags for receive, transmit and power-mode wake events. The top bit is a read-only busy indicator that covers the time a CSR read or write command is being carried out by an external access engine.

Hardware event pulses set the flags. Software writes set or clear them. The receive flag also has several hardware clear conditions and a conditional set from the invalidate command. Two interrupt outputs are formed from the flags, each gated by its own enable input. The buffer memory, the MAC, the CSR engine and the wake detector are outside the block and appear only as event and handshake pins.

Top module: `eth_bufctl_reg`

## Requirements
- R1: After reset, rd_data is 8'h00, cmd_stb is all zero, and irq_act and irq_pwr are low.
- R2: rd_data shows BUSY in bit 7, EPMF (power flag) in bit 6, TIF (transmit flag) in bit 5, RIF (receive flag) in bit 4 and the command field in bits 3:0.
- R3: A write of a valid code stores it in bits 3:0. In the following cycle exactly one cmd_stb bit is high while bits 3:0 still read the code. One cycle later the strobe is low and the field reads 0000. The code to strobe-bit map is: 0010→0 invalidate, 0011→1 flush, 0100→2 transmit, 0101→3 transmit without padding, 0110→4 transmit without CRC append, 1000→5 CSR write, 1001→6 CSR read, 1100→7 sleep on, 1101→8 sleep off.
- R4: A write of 0000 or of any reserved code (every code not listed in R3) gives no strobe and leaves the field at 0000.
- R5: BUSY goes high in the cycle after a CSR read or CSR write strobe. It goes low in the cycle after csr_done is sampled high. A CPU write to bit 7 has no effect on it.
- R6: A command written while BUSY is high, or while an earlier command is still pending, is ignored.
- R7: A wake_evt pulse sets EPMF and a tx_stat_evt pulse sets TIF. Every CPU write loads bits 6:4 into EPMF, TIF and RIF, so software can both set and clear the flags.
- R8: An rx_stat_evt pulse sets RIF. An invalidate strobe also sets RIF if rx_fifo_empty is low and RIF is clear.
- R9: RIF is cleared in the cycle after any of these: rx_fifo_empty rises, a flush strobe occurs, an invalidate strobe occurs with rx_fifo_single high, or bufsize_wr is high.
- R10: A hardware set of a flag wins over a software clear in the same cycle. A hardware clear of RIF wins over any set.
- R11: irq_act is high exactly when ie_act is high and TIF or RIF is set. irq_pwr is high exactly when ie_pwr is high and EPMF is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Register read value |
| cmd_stb | output | 9 | One-hot command strobes (map in R3) |
| csr_done | input | 1 | CSR access engine finished |
| rx_stat_evt | input | 1 | Receive status stored, FIFO updated |
| tx_stat_evt | input | 1 | Transmit status stored |
| wake_evt | input | 1 | Wake-up frame or magic packet detected |
| rx_fifo_empty | input | 1 | Receive FIFO empty level |
| rx_fifo_single | input | 1 | Receive FIFO holds exactly one packet |
| bufsize_wr | input | 1 | Buffer-size register being rewritten |
| ie_act | input | 1 | Activity interrupt enable |
| ie_pwr | input | 1 | Power mode interrupt enable |
| irq_act | output | 1 | Ethernet activity interrupt |
| irq_pwr | output | 1 | Ethernet power mode interrupt |

## Verification
Command dispatch is tested with every valid code, one after another, and then with every reserved code plus 0000. This separates a faulty decode table from a faulty self-clear of the field. CSR commands are sent again while BUSY is high to show that the busy gate works, and a write with bit 7 set shows that BUSY cannot be written. The flag logic is driven by single events, by software writes of both polarities, and by colliding event/write or set/clear pairs in the same cycle, which exposes wrong priority ordering. Each receive clear condition is applied on its own, so that a missing path shows up as RIF staying set.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int CODE_W    = 4;
  localparam int NUM_CMDS  = 9;
  localparam int NUM_FLAGS = 3;
  localparam int REG_W     = 8;
  localparam int FLAG_LSB  = CODE_W;
  localparam int BUSY_BIT  = REG_W - 1;

  // flag slots, in register order above the command field
  localparam int F_RX  = 0;
  localparam int F_TX  = 1;
  localparam int F_PWR = 2;

  // strobe indices
  localparam int S_INV     = 0;
  localparam int S_FLUSH   = 1;
  localparam int S_TX      = 2;
  localparam int S_TX_NPAD = 3;
  localparam int S_TX_NCRC = 4;
  localparam int S_CSR_WR  = 5;
  localparam int S_CSR_RD  = 6;
  localparam int S_SLP_ON  = 7;
  localparam int S_SLP_OFF = 8;

  typedef enum logic [CODE_W-1:0] {
    OP_NONE    = 4'b0000,
    OP_INV     = 4'b0010,
    OP_FLUSH   = 4'b0011,
    OP_TX      = 4'b0100,
    OP_TX_NPAD = 4'b0101,
    OP_TX_NCRC = 4'b0110,
    OP_CSR_WR  = 4'b1000,
    OP_CSR_RD  = 4'b1001,
    OP_SLP_ON  = 4'b1100,
    OP_SLP_OFF = 4'b1101
  } ebc_op_e;

  // one-hot strobe vector for a code; zero for no-op and reserved codes
  function automatic logic [NUM_CMDS-1:0] op_onehot(input logic [CODE_W-1:0] code);
    logic [NUM_CMDS-1:0] v;
    v = '0;
    case (code)
      OP_INV:     v[S_INV]     = 1'b1;
      OP_FLUSH:   v[S_FLUSH]   = 1'b1;
      OP_TX:      v[S_TX]      = 1'b1;
      OP_TX_NPAD: v[S_TX_NPAD] = 1'b1;
      OP_TX_NCRC: v[S_TX_NCRC] = 1'b1;
      OP_CSR_WR:  v[S_CSR_WR]  = 1'b1;
      OP_CSR_RD:  v[S_CSR_RD]  = 1'b1;
      OP_SLP_ON:  v[S_SLP_ON]  = 1'b1;
      OP_SLP_OFF: v[S_SLP_OFF] = 1'b1;
      default:    v = '0;
    endcase
    return v;
  endfunction

  // flag next state: hardware clear > hardware set > software write > hold
  function automatic logic flag_next(input logic cur, input logic hw_set,
                                     input logic hw_clr, input logic sw_we,
                                     input logic sw_val);
    if (hw_clr)      return 1'b0;
    else if (hw_set) return 1'b1;
    else if (sw_we)  return sw_val;
    else             return cur;
  endfunction
endpackage

// File: rtl/ebc_flag_cell.sv
module ebc_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic sw_we,
  input  logic sw_val,
  output logic q
);
  import ebc_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= flag_next(q, hw_set, hw_clr, sw_we, sw_val);
  end

  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_clr |=> !q);
  a_r10_set_beats_sw: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set && !hw_clr) |=> q);
  a_r7_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_set && !hw_clr && !sw_we) |=> $stable(q));
endmodule

// File: rtl/ebc_cmd_unit.sv
module ebc_cmd_unit
  import ebc_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int NC = NUM_CMDS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_code,
  input  logic          csr_done,
  output logic [CW-1:0] code_q,
  output logic          busy,
  output logic [NC-1:0] cmd_stb
);
  logic          take;
  logic          accept;
  logic          csr_go;
  logic [NC-1:0] wr_hot;

  assign wr_hot  = op_onehot(wr_code);
  assign cmd_stb = op_onehot(code_q);
  assign accept  = |cmd_stb;
  assign csr_go  = cmd_stb[S_CSR_WR] | cmd_stb[S_CSR_RD];
  assign take    = wr_en && !busy && (code_q == '0) && (|wr_hot);

  always_ff @(posedge clk) begin
    if (!rst_n)      code_q <= '0;
    else if (take)   code_q <= wr_code;
    else if (accept) code_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        busy <= 1'b0;
    else if (csr_go)   busy <= 1'b1;
    else if (csr_done) busy <= 1'b0;
  end

  a_r3_onehot_stb: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_stb));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_stb) |=> (cmd_stb == '0));
  a_r5_busy_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_stb[S_CSR_WR] | cmd_stb[S_CSR_RD]));
  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(code_q));
endmodule

// File: rtl/ebc_irq_gate.sv
module ebc_irq_gate
  import ebc_pkg::*;
#(
  parameter int NF = NUM_FLAGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] flags,
  input  logic          ie_act,
  input  logic          ie_pwr,
  output logic          irq_act,
  output logic          irq_pwr
);
  assign irq_act = ie_act & (flags[F_TX] | flags[F_RX]);
  assign irq_pwr = ie_pwr & flags[F_PWR];

  a_r11_pwr_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pwr |-> flags[F_PWR]);
  a_r11_act_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_act |-> !irq_act);
endmodule

// File: rtl/eth_bufctl_reg.sv
module eth_bufctl_reg
  import ebc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  output logic [NUM_CMDS-1:0] cmd_stb,
  input  logic                csr_done,
  input  logic                rx_stat_evt,
  input  logic                tx_stat_evt,
  input  logic                wake_evt,
  input  logic                rx_fifo_empty,
  input  logic                rx_fifo_single,
  input  logic                bufsize_wr,
  input  logic                ie_act,
  input  logic                ie_pwr,
  output logic                irq_act,
  output logic                irq_pwr
);
  logic [CODE_W-1:0]    code_q;
  logic                 busy;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] f_set;
  logic [NUM_FLAGS-1:0] f_clr;
  logic                 empty_q;
  logic                 rx_went_empty;
  logic                 inv_stb;
  logic                 rif_set;
  logic                 rif_clr;
  logic                 unused_busy_wr;

  assign unused_busy_wr = wr_data[BUSY_BIT];

  ebc_cmd_unit #(.CW(CODE_W), .NC(NUM_CMDS)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_code  (wr_data[CODE_W-1:0]),
    .csr_done (csr_done),
    .code_q   (code_q),
    .busy     (busy),
    .cmd_stb  (cmd_stb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) empty_q <= 1'b1;
    else        empty_q <= rx_fifo_empty;
  end

  assign rx_went_empty = rx_fifo_empty & ~empty_q;
  assign inv_stb       = cmd_stb[S_INV];
  assign rif_clr = rx_went_empty | cmd_stb[S_FLUSH] | (inv_stb & rx_fifo_single) | bufsize_wr;
  assign rif_set = rx_stat_evt | (inv_stb & ~rx_fifo_empty & ~flags[F_RX]);

  always_comb begin
    f_set        = '0;
    f_clr        = '0;
    f_set[F_RX]  = rif_set;
    f_clr[F_RX]  = rif_clr;
    f_set[F_TX]  = tx_stat_evt;
    f_set[F_PWR] = wake_evt;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    ebc_flag_cell u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (f_set[i]),
      .hw_clr (f_clr[i]),
      .sw_we  (wr_en),
      .sw_val (wr_data[FLAG_LSB+i]),
      .q      (flags[i])
    );
  end

  ebc_irq_gate #(.NF(NUM_FLAGS)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags),
    .ie_act  (ie_act),
    .ie_pwr  (ie_pwr),
    .irq_act (irq_act),
    .irq_pwr (irq_pwr)
  );

  assign rd_data = {busy, flags, code_q};

  a_r9_bufsize_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bufsize_wr |=> !rd_data[FLAG_LSB+F_RX]);
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb[S_FLUSH] |=> !rd_data[FLAG_LSB+F_RX]);
  a_r5_busy_no_sw: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && !(cmd_stb[S_CSR_WR] | cmd_stb[S_CSR_RD])) |=> !rd_data[BUSY_BIT]);
endmodule

// File: tb/tb_eth_bufctl_reg.sv
`timescale 1ns/1ps
module tb_eth_bufctl_reg;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [8:0] cmd_stb;
  logic       csr_done = 0, rx_stat_evt = 0, tx_stat_evt = 0, wake_evt = 0;
  logic       rx_fifo_empty = 1, rx_fifo_single = 0, bufsize_wr = 0;
  logic       ie_act = 0, ie_pwr = 0;
  logic       irq_act, irq_pwr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  eth_bufctl_reg dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    chk(cmd_stb == 0, "R1 cmd_stb", cmd_stb, 0);
    chk(!irq_act && !irq_pwr, "R1 irqs", {irq_act, irq_pwr}, 0);
  endtask

  task automatic t_valid_cmds();
    logic [3:0] codes [9] = '{4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h8, 4'h9, 4'hC, 4'hD};
    for (int i = 0; i < 9; i++) begin
      wr({4'h0, codes[i]});
      chk(cmd_stb == (9'd1 << i), "R3 strobe bit", cmd_stb, 9'd1 << i);
      chk(rd_data[3:0] == codes[i], "R2 field shows code", rd_data[3:0], codes[i]);
      cyc();
      chk(cmd_stb == 0 && rd_data[3:0] == 0, "R3 self-clear", {cmd_stb, rd_data[3:0]}, 0);
      if (i == 5 || i == 6) begin
        chk(rd_data[7] == 1, "R5 busy set", rd_data[7], 1);
        csr_done = 1; cyc(); csr_done = 0;
        chk(rd_data[7] == 0, "R5 busy cleared", rd_data[7], 0);
      end
    end
  endtask

  task automatic t_reserved();
    logic [3:0] codes [8] = '{4'h0, 4'h1, 4'h7, 4'hA, 4'hB, 4'hE, 4'hF, 4'h0};
    for (int i = 0; i < 7; i++) begin
      wr({4'h0, codes[i]});
      chk(cmd_stb == 0 && rd_data[3:0] == 0, "R4 reserved ignored", {cmd_stb, rd_data[3:0]}, 0);
      cyc();
      chk(cmd_stb == 0 && rd_data[3:0] == 0, "R4 reserved later", {cmd_stb, rd_data[3:0]}, 0);
    end
  endtask

  task automatic t_busy();
    wr(8'h89);
    chk(cmd_stb == 9'd1 << 6, "R3 csr read strobe", cmd_stb, 9'd1 << 6);
    cyc();
    chk(rd_data[7] == 1, "R5 busy after csr read", rd_data[7], 1);
    wr(8'h83);
    chk(cmd_stb == 0 && rd_data[3:0] == 0, "R6 cmd ignored while busy", {cmd_stb, rd_data[3:0]}, 0);
    cyc();
    chk(cmd_stb == 0, "R6 no late strobe", cmd_stb, 0);
    wr(8'h00);
    chk(rd_data[7] == 1, "R5 write cannot clear busy", rd_data[7], 1);
    csr_done = 1; cyc(); csr_done = 0;
    chk(rd_data[7] == 0, "R5 done clears busy", rd_data[7], 0);
    wr(8'h80);
    cyc();
    chk(rd_data[7] == 0, "R5 write cannot set busy", rd_data[7], 0);
  endtask

  task automatic t_flags();
    ie_pwr = 1; ie_act = 1;
    wake_evt = 1; cyc(); wake_evt = 0;
    chk(rd_data[6] == 1, "R7 wake sets power flag", rd_data[6], 1);
    chk(irq_pwr == 1, "R11 power irq", irq_pwr, 1);
    ie_pwr = 0; #0.1;
    chk(irq_pwr == 0, "R11 power irq masked", irq_pwr, 0);
    tx_stat_evt = 1; cyc(); tx_stat_evt = 0;
    chk(rd_data[6:4] == 3'b110, "R7 tx sets transmit flag", rd_data[6:4], 3'b110);
    chk(irq_act == 1, "R11 activity irq from TIF", irq_act, 1);
    wr(8'h00);
    chk(rd_data[6:4] == 0, "R7 software clears", rd_data[6:4], 0);
    chk(irq_act == 0, "R11 activity irq drops", irq_act, 0);
    wr(8'h20);
    chk(rd_data[5] == 1, "R7 software sets TIF", rd_data[5], 1);
    wr(8'h00);
    ie_act = 0;
  endtask

  task automatic t_rif();
    rx_stat_evt = 1; cyc(); rx_stat_evt = 0;
    chk(rd_data[4] == 1, "R8 rx status sets RIF", rd_data[4], 1);
    ie_act = 1; #0.1;
    chk(irq_act == 1, "R11 activity irq from RIF", irq_act, 1);
    ie_act = 0;
    rx_fifo_empty = 0; rx_fifo_single = 0;
    wr(8'h02); cyc();
    chk(rd_data[4] == 1, "R8 invalidate sets RIF", rd_data[4], 1);
    rx_fifo_single = 1;
    wr(8'h12); cyc();
    chk(rd_data[4] == 0, "R9 invalidate last packet clears", rd_data[4], 0);
    rx_fifo_single = 0;
    wr(8'h13); cyc();
    chk(rd_data[4] == 0, "R9 flush clears", rd_data[4], 0);
    wr(8'h10);
    chk(rd_data[4] == 1, "R7 software sets RIF", rd_data[4], 1);
    bufsize_wr = 1; cyc(); bufsize_wr = 0;
    chk(rd_data[4] == 0, "R9 bufsize clears", rd_data[4], 0);
    wr(8'h10);
    rx_fifo_empty = 1; cyc();
    chk(rd_data[4] == 0, "R9 fifo emptied clears", rd_data[4], 0);
  endtask

  task automatic t_prio();
    @(negedge clk); tx_stat_evt = 1; wr_en = 1; wr_data = 8'h00;
    @(negedge clk); tx_stat_evt = 0; wr_en = 0;
    chk(rd_data[5] == 1, "R10 hw set beats sw clear", rd_data[5], 1);
    @(negedge clk); rx_stat_evt = 1; bufsize_wr = 1;
    @(negedge clk); rx_stat_evt = 0; bufsize_wr = 0;
    chk(rd_data[4] == 0, "R10 hw clear beats set", rd_data[4], 0);
    @(negedge clk); wr_en = 1; wr_data = 8'h10; bufsize_wr = 1;
    @(negedge clk); wr_en = 0; bufsize_wr = 0;
    chk(rd_data[4] == 0, "R10 hw clear beats sw set", rd_data[4], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_valid_cmds();
    t_reserved();
    t_busy();
    t_flags();
    t_rif();
    t_prio();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule